// File: doc/BRIEF.md
# Trigger Latency Pipeline with Event Derandomizer

This block holds the binary hit pattern of a 128-channel strip front end long enough for a level-1 trigger decision to arrive. On every bunch-crossing clock it stores the current 128-bit pattern, one bit per channel, in a 256-deep circular store. That depth covers 6.4 us of history at 25 ns per crossing.

When a trigger arrives, the block takes the pattern that was stored a programmable number of crossings earlier. It tags that pattern with the current bunch-crossing count and trigger count, then queues the result in an eight-event derandomizer. A readout controller drains the queue at its own pace. It sees the oldest event on the outputs whenever the queue is not empty, and removes that event with a pop strobe.

If a trigger finds the queue full, the event is lost. The trigger is still counted, so the trigger count stays aligned with the trigger stream seen elsewhere in the system, and a sticky overflow flag records the loss.

Top module: `hlb_latency_buffer`

## Requirements
- R1: With a latency value L between 1 and 255, a trigger queues the hit pattern that was presented L cycles before the trigger cycle.
- R2: With latency 0, a trigger queues the hit pattern presented in the trigger cycle itself.
- R3: The look-back wraps around the 256-entry store. A trigger whose look-back reaches behind store address 0 still returns the correct older pattern, and this holds once more than 256 crossings have passed.
- R4: The crossing count is 0 in the first cycle after reset is released and rises by one every cycle, wrapping from 255 to 0. A queued event carries the count of its trigger cycle.
- R5: A queued event carries the number of triggers seen since reset, modulo 16, excluding itself. Dropped triggers are included in that number.
- R6: The queue delivers events in trigger order. The oldest event is visible on the event outputs whenever the queue is not empty, and a pop in a non-empty cycle removes that event.
- R7: The empty flag is high exactly when no event is queued. The full flag is high exactly when 8 events are queued.
- R8: A trigger in a cycle where the queue is full is discarded and sets the overflow flag. The flag stays set until reset.
- R9: A pop in a cycle where the queue is empty has no effect.
- R10: A synchronous reset empties the queue, clears the overflow flag and clears both counters.
- R11: A trigger and a pop in the same cycle: when the queue is full, the pop is taken and the trigger is dropped. When the queue is empty, the trigger is queued and the pop is ignored. Otherwise both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous reset, active high |
| hit_slice | input | 128 | Hit pattern of the current crossing, one bit per channel |
| l1_trig | input | 1 | Level-1 trigger strobe |
| latency | input | 8 | Look-back distance in crossings |
| rd_pop | input | 1 | Removes the oldest queued event |
| ev_slice | output | 128 | Hit pattern of the oldest queued event |
| ev_bc | output | 8 | Crossing count of the oldest queued event |
| ev_l1 | output | 4 | Trigger count of the oldest queued event |
| ev_empty | output | 1 | Queue holds no event |
| ev_full | output | 1 | Queue holds 8 events |
| ev_overflow | output | 1 | Sticky flag, set when a trigger was dropped |

## Verification
A wrong write pointer or look-back address shows up as a wrong pattern on ev_slice. This happens in the cycle after the affected trigger if the queue was empty, otherwise as soon as that event reaches the head. A stalled or skipping counter appears in ev_bc or ev_l1 of the next event to reach the head.

A wrong occupancy count shows up in the flags no later than the next push or pop, because empty and full are compared with a reference queue on every clock. Latency 0, look-backs that cross address 0, and triggers arriving on a full queue each get their own stimulus, because each of them follows a separate path in the logic.

// File: rtl/hlb_pkg.sv
package hlb_pkg;

  localparam int unsigned HLB_CH   = 128;
  localparam int unsigned HLB_RING = 256;
  localparam int unsigned HLB_EVT  = 8;
  localparam int unsigned HLB_BCW  = 8;
  localparam int unsigned HLB_L1W  = 4;

  // Index reached by stepping 'back' positions behind 'wr' in a ring of 'depth'.
  function automatic int unsigned ring_back(int unsigned wr, int unsigned back,
                                            int unsigned depth);
    return (wr + depth - (back % depth)) % depth;
  endfunction

  // Successor of 'v' in a ring of 'modulus' positions.
  function automatic int unsigned wrap_inc(int unsigned v, int unsigned modulus);
    return (v + 1) % modulus;
  endfunction

endpackage

// File: rtl/hlb_wrap_counter.sv
module hlb_wrap_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (inc) q <= q + W'(1);
  end

endmodule

// File: rtl/hlb_ring_store.sv
module hlb_ring_store
  import hlb_pkg::*;
#(
  parameter int unsigned WIDTH       = HLB_CH,
  parameter int unsigned DEPTH       = HLB_RING,
  parameter bit          BYPASS_ZERO = 1'b1,
  localparam int unsigned AW         = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  input  logic [AW-1:0]    back,
  output logic [WIDTH-1:0] tap,
  output logic [AW-1:0]    wr_addr,
  output logic [AW-1:0]    rd_addr
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_q;

  always_ff @(posedge clk) begin
    if (rst) wr_q <= '0;
    else     wr_q <= AW'(wrap_inc(32'(wr_q), DEPTH));
  end

  always_ff @(posedge clk) begin
    if (!rst) mem[wr_q] <= din;
  end

  assign wr_addr = wr_q;
  assign rd_addr = AW'(ring_back(32'(wr_q), 32'(back), DEPTH));

  generate
    if (BYPASS_ZERO) begin : g_bypass
      // A zero look-back means the pattern being written in this very cycle.
      assign tap = (back == '0) ? din : mem[rd_addr];
    end else begin : g_plain
      assign tap = mem[rd_addr];
    end
  endgenerate

endmodule

// File: rtl/hlb_derand_fifo.sv
module hlb_derand_fifo
  import hlb_pkg::*;
#(
  parameter int unsigned DW    = HLB_CH + HLB_BCW + HLB_L1W,
  parameter int unsigned DEPTH = HLB_EVT,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          full,
  output logic          push_ok,
  output logic          pop_ok
);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= PW'(wrap_inc(32'(wp), DEPTH));
      if (pop_ok)  rp <= PW'(wrap_inc(32'(rp), DEPTH));
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  assign dout = mem[rp];

endmodule

// File: rtl/hlb_latency_buffer.sv
module hlb_latency_buffer
  import hlb_pkg::*;
#(
  parameter int unsigned CH   = HLB_CH,
  parameter int unsigned RING = HLB_RING,
  parameter int unsigned EVT  = HLB_EVT,
  parameter int unsigned BCW  = HLB_BCW,
  parameter int unsigned L1W  = HLB_L1W,
  localparam int unsigned AW  = $clog2(RING),
  localparam int unsigned EW  = CH + BCW + L1W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [CH-1:0]  hit_slice,
  input  logic           l1_trig,
  input  logic [AW-1:0]  latency,
  input  logic           rd_pop,
  output logic [CH-1:0]  ev_slice,
  output logic [BCW-1:0] ev_bc,
  output logic [L1W-1:0] ev_l1,
  output logic           ev_empty,
  output logic           ev_full,
  output logic           ev_overflow
);

  logic [CH-1:0]  tap;
  logic [AW-1:0]  wr_addr, rd_addr;
  logic [BCW-1:0] bc_q;
  logic [L1W-1:0] l1_q;
  logic [EW-1:0]  ev_in, ev_out;
  logic           push_acc, pop_acc, drop_evt, ovf_q;

  hlb_ring_store #(.WIDTH(CH), .DEPTH(RING)) i_ring (
    .clk(clk), .rst(rst), .din(hit_slice), .back(latency),
    .tap(tap), .wr_addr(wr_addr), .rd_addr(rd_addr)
  );

  hlb_wrap_counter #(.W(BCW)) i_bc_cnt (
    .clk(clk), .rst(rst), .inc(1'b1), .q(bc_q)
  );

  // Every trigger is counted, dropped or not.
  hlb_wrap_counter #(.W(L1W)) i_l1_cnt (
    .clk(clk), .rst(rst), .inc(l1_trig), .q(l1_q)
  );

  assign ev_in = {tap, bc_q, l1_q};

  hlb_derand_fifo #(.DW(EW), .DEPTH(EVT)) i_derand (
    .clk(clk), .rst(rst), .push(l1_trig), .pop(rd_pop), .din(ev_in),
    .dout(ev_out), .empty(ev_empty), .full(ev_full),
    .push_ok(push_acc), .pop_ok(pop_acc)
  );

  assign drop_evt = l1_trig && !push_acc;

  always_ff @(posedge clk) begin
    if (rst)           ovf_q <= 1'b0;
    else if (drop_evt) ovf_q <= 1'b1;
  end

  assign ev_overflow = ovf_q;
  assign {ev_slice, ev_bc, ev_l1} = ev_out;

endmodule

// File: rtl/hlb_checker.sv
module hlb_checker #(
  parameter int unsigned BCW = 8,
  parameter int unsigned L1W = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           l1_trig,
  input logic           rd_pop,
  input logic           ev_empty,
  input logic           ev_full,
  input logic           ev_overflow,
  input logic [BCW-1:0] bc_cnt,
  input logic [L1W-1:0] l1_cnt,
  input logic           push_acc,
  input logic           pop_acc
);

  logic armed = 1'b0;
  always_ff @(posedge clk) if (rst) armed <= 1'b1;

  p_bc_step_r4: assert property (@(posedge clk) disable iff (rst || !armed)
    !$past(rst) |-> bc_cnt == $past(bc_cnt) + BCW'(1));

  p_l1_step_r5: assert property (@(posedge clk) disable iff (rst || !armed)
    l1_trig |=> l1_cnt == $past(l1_cnt) + L1W'(1));

  p_push_fills_r6: assert property (@(posedge clk) disable iff (rst || !armed)
    push_acc |=> !ev_empty);

  p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (rst || !armed)
    !(ev_empty && ev_full));

  p_full_drop_r8: assert property (@(posedge clk) disable iff (rst || !armed)
    l1_trig && ev_full |=> ev_overflow);

  p_overflow_sticky_r8: assert property (@(posedge clk) disable iff (rst || !armed)
    ev_overflow |=> ev_overflow);

  p_empty_pop_r9: assert property (@(posedge clk) disable iff (rst || !armed)
    ev_empty && !l1_trig |=> ev_empty);

  p_no_pop_when_empty_r9: assert property (@(posedge clk) disable iff (rst || !armed)
    rd_pop && ev_empty |-> !pop_acc);

  p_reset_clears_r10: assert property (@(posedge clk)
    armed && $past(rst) |-> ev_empty && !ev_overflow && bc_cnt == '0 && l1_cnt == '0);

  p_full_pop_drop_r11: assert property (@(posedge clk) disable iff (rst || !armed)
    ev_full && l1_trig && rd_pop |=> !ev_full && ev_overflow);

endmodule

bind hlb_latency_buffer hlb_checker #(.BCW(BCW), .L1W(L1W)) i_chk (
  .clk(clk), .rst(rst), .l1_trig(l1_trig), .rd_pop(rd_pop),
  .ev_empty(ev_empty), .ev_full(ev_full), .ev_overflow(ev_overflow),
  .bc_cnt(bc_q), .l1_cnt(l1_q), .push_acc(push_acc), .pop_acc(pop_acc)
);

// File: tb/test_hlb_latency_buffer.sv
`timescale 1ns/1ps
module test_hlb_latency_buffer;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] hit_slice = '0;
  logic         l1_trig = 1'b0;
  logic [7:0]   latency = '0;
  logic         rd_pop = 1'b0;
  logic [127:0] ev_slice;
  logic [7:0]   ev_bc;
  logic [3:0]   ev_l1;
  logic         ev_empty, ev_full, ev_overflow;

  always #2 clk = ~clk;

  hlb_latency_buffer i_hlb_latency_buffer (
    .clk(clk), .rst(rst), .hit_slice(hit_slice), .l1_trig(l1_trig),
    .latency(latency), .rd_pop(rd_pop), .ev_slice(ev_slice), .ev_bc(ev_bc),
    .ev_l1(ev_l1), .ev_empty(ev_empty), .ev_full(ev_full),
    .ev_overflow(ev_overflow)
  );

  typedef struct {
    logic [127:0] s;
    int           bc;
    int           l1;
    string        tag;
  } ev_t;

  logic [127:0] hist[$];
  ev_t          q[$];
  int           since = 0;
  int           l1m = 0;
  bit           ovm = 1'b0;
  int           checks = 0;
  int           fails = 0;
  bit           done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare();
    chk(ev_empty === (q.size() == 0), "R7 empty", 128'(ev_empty), 128'(q.size() == 0));
    chk(ev_full === (q.size() == 8), "R7 full", 128'(ev_full), 128'(q.size() == 8));
    chk(ev_overflow === ovm, "R8 overflow", 128'(ev_overflow), 128'(ovm));
    if (q.size() > 0) begin
      chk(ev_slice === q[0].s, {q[0].tag, " R6 slice"}, ev_slice, q[0].s);
      chk(ev_bc === 8'(q[0].bc), "R4 bc", 128'(ev_bc), 128'(q[0].bc % 256));
      chk(ev_l1 === 4'(q[0].l1), "R5 l1", 128'(ev_l1), 128'(q[0].l1 % 16));
    end
  endtask

  // One crossing: check the state, drive the inputs, advance the reference.
  task automatic cyc(input bit r, input bit t, input bit p, input int lat);
    logic [127:0] h;
    int pre;
    @(negedge clk);
    compare();
    h = {$urandom, $urandom, $urandom, $urandom};
    rst = r; l1_trig = t; rd_pop = p; latency = 8'(lat); hit_slice = h;
    if (r) begin
      hist.delete(); q.delete(); since = 0; l1m = 0; ovm = 1'b0;
    end else begin
      hist.push_back(h);
      pre = q.size();
      if (p && pre > 0) void'(q.pop_front());
      if (t) begin
        if (pre >= 8) ovm = 1'b1;
        else if (lat < hist.size()) begin
          ev_t e;
          e.s  = hist[hist.size() - 1 - lat];
          e.bc = since % 256;
          e.l1 = l1m % 16;
          e.tag = (lat == 0) ? "R2" : (((since % 256) < lat) ? "R3" : "R1");
          q.push_back(e);
        end
        l1m++;
      end
      since++;
      if (hist.size() > 400) void'(hist.pop_front());
    end
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 0);
  endtask

  task automatic drain();
    while (q.size() > 0) cyc(1'b0, 1'b0, 1'b1, 0);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0, 0);
    #1;
    chk(ev_empty === 1'b1 && ev_overflow === 1'b0, "R10 reset state",
        128'({ev_empty, ev_overflow}), 128'(2'b10));

    // Basic look-back distances
    idle(20);
    cyc(1'b0, 1'b1, 1'b0, 5);    // R1
    cyc(1'b0, 1'b1, 1'b0, 0);    // R2
    cyc(1'b0, 1'b1, 1'b0, 1);    // R1
    cyc(1'b0, 1'b1, 1'b1, 19);   // R11: trigger and pop together
    idle(2);
    drain();

    // Long history, look-back across address 0 and counter wrap
    idle(290);
    cyc(1'b0, 1'b1, 1'b0, 255);  // R1, full depth
    cyc(1'b0, 1'b1, 1'b0, 100);  // R3, crosses address 0
    cyc(1'b0, 1'b1, 1'b0, 200);  // R3
    idle(3);
    drain();

    // Fill, overflow, simultaneous trigger and pop on a full queue
    for (int i = 0; i < 9; i++) cyc(1'b0, 1'b1, 1'b0, 3);
    #1;
    chk(ev_full === 1'b1 && ev_overflow === 1'b1, "R8 drop on full",
        128'({ev_full, ev_overflow}), 128'(2'b11));
    cyc(1'b0, 1'b1, 1'b1, 2);
    #1;
    chk(ev_full === 1'b0, "R11 full queue drops trigger but pops",
        128'(ev_full), 128'(0));
    drain();

    // Pops on an empty queue
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b1, 0);
    #1;
    chk(ev_empty === 1'b1 && ev_full === 1'b0, "R9 pop on empty ignored",
        128'({ev_empty, ev_full}), 128'(2'b10));
    cyc(1'b0, 1'b1, 1'b1, 0);    // R11 on empty queue: trigger kept
    #1;
    chk(ev_empty === 1'b0, "R11 empty queue keeps trigger", 128'(ev_empty), 128'(0));
    idle(2);

    // Reset in the middle of traffic
    cyc(1'b0, 1'b1, 1'b0, 4);
    cyc(1'b1, 1'b0, 1'b0, 0);
    #1;
    chk(ev_empty === 1'b1 && ev_overflow === 1'b0, "R10 mid-run reset",
        128'({ev_empty, ev_overflow}), 128'(2'b10));
    idle(6);
    cyc(1'b0, 1'b1, 1'b0, 2);
    cyc(1'b0, 1'b1, 1'b0, 0);
    idle(2);
    drain();
    idle(2);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule